// File: doc/BRIEF.md
# ALU Condition and Control Flags Register

This block holds the processor's 16-bit flags word. Each time the execution unit finishes an arithmetic or logical operation it presents its two operands, the result, the carry (or borrow) out of the top bit and the carry out of bit 3, together with the operation kind and width. When the update enable is high, the block derives six condition flags from these inputs and registers them on the next clock edge. The six flags are carry, parity, half-carry, zero, sign and overflow.

Three control flags are kept beside the condition flags: single-step, interrupt enable and string direction. Arithmetic and logical updates never change them. They move only when the set or clear command vector names them. The interrupt-enable flag also masks an external interrupt request, so the block can hand a gated request straight to the interrupt logic. The packed word is available for pushing to a stack, and the three control flags are also brought out as separate pins.

Top module: `alu_flags_reg`

## Requirements
- R1: After reset the flags word reads 16'h0002 and int_en, dir_down and single_step are 0.
- R2: On an update with op_kind 0 (add) or 1 (subtract), the carry flag (bit 0) takes carry_out. On an update with op_kind 2 or 3 (logical), both the carry flag and the overflow flag (bit 11) are cleared, whatever carry_out is.
- R3: On an update the parity flag (bit 2) is 1 when result[7:0] holds an even number of ones and 0 otherwise, in both widths.
- R4: On an arithmetic update the half-carry flag (bit 4) takes half_carry. On a logical update it keeps its previous value.
- R5: On an update the zero flag (bit 6) is set when the active part of the result is zero. The active part is result[7:0] when byte_mode is 1 and result[15:0] when it is 0.
- R6: On an update the sign flag (bit 7) copies result[7] in byte mode and result[15] in word mode.
- R7: On an arithmetic update the overflow flag (bit 11) is set when the true signed sum (add) or difference opnd_a minus opnd_b (subtract) of the active-width operands falls outside the signed range of that width.
- R8: While upd_en is 0, all six condition flags keep their values.
- R9: Control flag k changes only through ctl_set[k] or ctl_clr[k], where k=0 is single-step (bit 8), k=1 is interrupt enable (bit 9) and k=2 is direction (bit 10). When both are asserted, the clear takes effect.
- R10: irq_take is high exactly when irq_req is high and the registered interrupt-enable flag is 1.
- R11: Bit 1 of the word always reads 1, and bits 3, 5 and 12 to 15 always read 0. The flags sit at these positions: carry 0, parity 2, half-carry 4, zero 6, sign 7, single-step 8, interrupt enable 9, direction 10, overflow 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_en | input | 1 | Load condition flags from the current operation |
| op_kind | input | 2 | 0 add, 1 subtract, 2 or 3 logical |
| byte_mode | input | 1 | 1: 8-bit operation, 0: 16-bit operation |
| opnd_a | input | 16 | First operand (minuend for subtract) |
| opnd_b | input | 16 | Second operand (subtrahend for subtract) |
| result | input | 16 | ALU result |
| carry_out | input | 1 | Carry or borrow out of the active top bit |
| half_carry | input | 1 | Carry or borrow out of bit 3 |
| ctl_set | input | 3 | Set commands for single-step, interrupt enable, direction |
| ctl_clr | input | 3 | Clear commands for the same three flags |
| irq_req | input | 1 | External interrupt request |
| flags_word | output | 16 | Packed flags word |
| int_en | output | 1 | Interrupt-enable flag |
| dir_down | output | 1 | Direction flag |
| single_step | output | 1 | Single-step flag |
| irq_take | output | 1 | Interrupt request gated by int_en |

## Verification
The hardest case to reach is signed overflow at the width boundary in byte mode while the upper result and operand bits hold unrelated values. A wrong choice of sign bit or zero range only shows up in that situation. The bench sweeps every first operand against a spread of second operands for both add and subtract in byte mode, with garbage in the upper halves. It derives the expected overflow from a signed range comparison instead of a sign-bit rule. Word mode uses pseudo-random pairs plus the pairs that sit exactly on the signed limits. All of this runs while control flags are held set, so the sweep also shows that arithmetic leaves them alone.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    localparam int FLAG_W = 16;
    localparam logic [FLAG_W-1:0] FIXED_ONES = 16'h0002;

    localparam int POS_CY   = 0;
    localparam int POS_PAR  = 2;
    localparam int POS_HC   = 4;
    localparam int POS_ZR   = 6;
    localparam int POS_SG   = 7;
    localparam int POS_STEP = 8;
    localparam int POS_IE   = 9;
    localparam int POS_DIR  = 10;
    localparam int POS_OV   = 11;

    localparam int CTL_N    = 3;
    localparam int CTL_STEP = 0;
    localparam int CTL_IE   = 1;
    localparam int CTL_DIR  = 2;

    typedef enum logic [1:0] {
        OPK_ADD  = 2'd0,
        OPK_SUB  = 2'd1,
        OPK_LOG0 = 2'd2,
        OPK_LOG1 = 2'd3
    } op_kind_e;

    typedef struct packed {
        logic cy;
        logic par;
        logic hc;
        logic zr;
        logic sg;
        logic ov;
    } cond_t;

    typedef struct packed {
        cond_t            cond;
        logic [CTL_N-1:0] ctl;
    } flag_state_t;

endpackage

// File: rtl/flag_cond_eval.sv
module flag_cond_eval
    import alu_flags_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8,
    parameter int PAR_W    = 8
) (
    input  logic [1:0]        op_kind,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] result,
    input  logic              carry_out,
    input  logic              half_carry,
    input  logic              prev_hc,
    output cond_t             cond_nxt
);
    localparam int TOP_W = DATA_W - 1;
    localparam int TOP_N = NARROW_W - 1;

    op_kind_e kind;
    logic     is_logic;
    logic     is_sub;
    logic     sa, sb, sr;
    logic     zero_w, zero_n;

    always_comb begin
        kind     = op_kind_e'(op_kind);
        is_logic = (kind == OPK_LOG0) || (kind == OPK_LOG1);
        is_sub   = (kind == OPK_SUB);

        sa = byte_mode ? opnd_a[TOP_N] : opnd_a[TOP_W];
        sb = byte_mode ? opnd_b[TOP_N] : opnd_b[TOP_W];
        sr = byte_mode ? result[TOP_N] : result[TOP_W];

        zero_n = ~|result[TOP_N:0];
        zero_w = ~|result;

        cond_nxt.par = ~^result[PAR_W-1:0];
        cond_nxt.zr  = byte_mode ? zero_n : zero_w;
        cond_nxt.sg  = sr;

        if (is_logic) begin
            cond_nxt.cy = 1'b0;
            cond_nxt.ov = 1'b0;
            cond_nxt.hc = prev_hc;
        end else begin
            cond_nxt.cy = carry_out;
            cond_nxt.hc = half_carry;
            if (is_sub) begin
                cond_nxt.ov = (sa != sb) && (sr != sa);
            end else begin
                cond_nxt.ov = (sa == sb) && (sr != sa);
            end
        end
    end

endmodule

// File: rtl/flag_ctl_update.sv
module flag_ctl_update
    import alu_flags_pkg::*;
(
    input  logic [CTL_N-1:0] ctl_cur,
    input  logic [CTL_N-1:0] ctl_set,
    input  logic [CTL_N-1:0] ctl_clr,
    output logic [CTL_N-1:0] ctl_nxt
);
    for (genvar k = 0; k < CTL_N; k++) begin : g_bit
        always_comb begin
            if (ctl_clr[k]) begin
                ctl_nxt[k] = 1'b0;
            end else if (ctl_set[k]) begin
                ctl_nxt[k] = 1'b1;
            end else begin
                ctl_nxt[k] = ctl_cur[k];
            end
        end
    end

endmodule

// File: rtl/alu_flags_reg.sv
module alu_flags_reg
    import alu_flags_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [1:0]        op_kind,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] result,
    input  logic              carry_out,
    input  logic              half_carry,
    input  logic [2:0]        ctl_set,
    input  logic [2:0]        ctl_clr,
    input  logic              irq_req,
    output logic [15:0]       flags_word,
    output logic              int_en,
    output logic              dir_down,
    output logic              single_step,
    output logic              irq_take
);
    flag_state_t      st_d, st_q;
    cond_t            cond_nxt;
    logic [CTL_N-1:0] ctl_nxt;

    flag_cond_eval #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W),
        .PAR_W    (8)
    ) u_cond (
        .op_kind    (op_kind),
        .byte_mode  (byte_mode),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .result     (result),
        .carry_out  (carry_out),
        .half_carry (half_carry),
        .prev_hc    (st_q.cond.hc),
        .cond_nxt   (cond_nxt)
    );

    flag_ctl_update u_ctl (
        .ctl_cur (st_q.ctl),
        .ctl_set (ctl_set),
        .ctl_clr (ctl_clr),
        .ctl_nxt (ctl_nxt)
    );

    always_comb begin
        st_d = st_q;
        if (upd_en) begin
            st_d.cond = cond_nxt;
        end
        st_d.ctl = ctl_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        flags_word           = FIXED_ONES;
        flags_word[POS_CY]   = st_q.cond.cy;
        flags_word[POS_PAR]  = st_q.cond.par;
        flags_word[POS_HC]   = st_q.cond.hc;
        flags_word[POS_ZR]   = st_q.cond.zr;
        flags_word[POS_SG]   = st_q.cond.sg;
        flags_word[POS_OV]   = st_q.cond.ov;
        flags_word[POS_STEP] = st_q.ctl[CTL_STEP];
        flags_word[POS_IE]   = st_q.ctl[CTL_IE];
        flags_word[POS_DIR]  = st_q.ctl[CTL_DIR];

        single_step = st_q.ctl[CTL_STEP];
        int_en      = st_q.ctl[CTL_IE];
        dir_down    = st_q.ctl[CTL_DIR];
        irq_take    = irq_req & st_q.ctl[CTL_IE];
    end

endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        upd_en,
    input logic [1:0]  op_kind,
    input logic [7:0]  res_lo,
    input logic [2:0]  ctl_set,
    input logic [2:0]  ctl_clr,
    input logic        irq_req,
    input logic [15:0] flags_word,
    input logic        int_en,
    input logic        irq_take
);
    logic [5:0] cond_bits;
    assign cond_bits = {flags_word[11], flags_word[7], flags_word[6],
                        flags_word[4], flags_word[2], flags_word[0]};

    // R8
    hold_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(cond_bits));

    // R2
    logic_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_kind[1]) |=> (!flags_word[0] && !flags_word[11]));

    // R4
    hc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_kind[1]) |=> $stable(flags_word[4]));

    // R3
    parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (flags_word[2] == ~^$past(res_lo)));

    // R9
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_set == 3'b000 && ctl_clr == 3'b000) |=> $stable(flags_word[10:8]));

    // R9
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_clr[1] |=> !int_en);

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (irq_req && int_en));

endmodule

bind alu_flags_reg alu_flags_chk u_flags_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_en     (upd_en),
    .op_kind    (op_kind),
    .res_lo     (result[7:0]),
    .ctl_set    (ctl_set),
    .ctl_clr    (ctl_clr),
    .irq_req    (irq_req),
    .flags_word (flags_word),
    .int_en     (int_en),
    .irq_take   (irq_take)
);

// File: tb/alu_flags_reg_bench.sv
module alu_flags_reg_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_en = 1'b0;
    logic [1:0]  op_kind = 2'd0;
    logic        byte_mode = 1'b0;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic [15:0] result = '0;
    logic        carry_out = 1'b0;
    logic        half_carry = 1'b0;
    logic [2:0]  ctl_set = '0;
    logic [2:0]  ctl_clr = '0;
    logic        irq_req = 1'b0;
    logic [15:0] flags_word;
    logic        int_en, dir_down, single_step, irq_take;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [31:0] lcg = 32'h1234_5678;

    // expected model
    bit e_cy, e_par, e_hc, e_zr, e_sg, e_ov;
    bit [2:0] e_ctl;

    always #10 clk = ~clk;

    alu_flags_reg u_alu_flags_reg (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_kind(op_kind),
        .byte_mode(byte_mode), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .result(result), .carry_out(carry_out), .half_carry(half_carry),
        .ctl_set(ctl_set), .ctl_clr(ctl_clr), .irq_req(irq_req),
        .flags_word(flags_word), .int_en(int_en), .dir_down(dir_down),
        .single_step(single_step), .irq_take(irq_take)
    );

    function automatic logic [15:0] exp_word();
        logic [15:0] w;
        w = 16'h0002;
        w[0] = e_cy;  w[2] = e_par; w[4] = e_hc; w[6] = e_zr;
        w[7] = e_sg;  w[11] = e_ov;
        w[8] = e_ctl[0]; w[9] = e_ctl[1]; w[10] = e_ctl[2];
        return w;
    endfunction

    function automatic logic [31:0] rnd();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return lcg;
    endfunction

    task automatic cmp(string req, logic [18:0] got, logic [18:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // inputs are already driven; pass one rising edge, then compare
    task automatic tick(string req);
        e_ctl = (e_ctl | ctl_set) & ~ctl_clr;
        @(negedge clk);
        cmp(req, {flags_word, int_en, dir_down, single_step},
            {exp_word(), e_ctl[1], e_ctl[2], e_ctl[0]});
    endtask

    task automatic arith(bit sub, bit bm, int a_in, int b_in, logic [7:0] junk);
        int w, mask, a, b, half, sa, sb, sr, full, res;
        w = bm ? 8 : 16;
        mask = (1 << w) - 1;
        half = 1 << (w - 1);
        a = a_in & mask;
        b = b_in & mask;
        sa = (a >= half) ? a - (1 << w) : a;
        sb = (b >= half) ? b - (1 << w) : b;
        if (sub) begin
            full = a - b;
            sr = sa - sb;
            carry_out = (a < b);
            half_carry = ((a & 15) < (b & 15));
        end else begin
            full = a + b;
            sr = sa + sb;
            carry_out = full[w];
            half_carry = (((a & 15) + (b & 15)) > 15);
        end
        res = full & mask;
        upd_en = 1'b1;
        op_kind = sub ? 2'd1 : 2'd0;
        byte_mode = bm;
        opnd_a = 16'(a);
        opnd_b = 16'(b);
        result = 16'(res);
        if (bm) begin
            opnd_a[15:8] = junk;
            opnd_b[15:8] = ~junk;
            result[15:8] = junk ^ 8'h5A;
        end
        e_cy = carry_out;
        e_hc = half_carry;
        e_par = ~^result[7:0];
        e_zr = (res == 0);
        e_sg = res[w-1];
        e_ov = (sr >= half) || (sr < -half);
        tick("R2/R3/R4/R5/R6/R7/R9/R11");
    endtask

    task automatic logic_op(bit bm, logic [15:0] r, logic [1:0] k);
        upd_en = 1'b1;
        op_kind = k;
        byte_mode = bm;
        result = r;
        opnd_a = r ^ 16'h3C3C;
        opnd_b = ~r;
        carry_out = 1'b1;
        half_carry = ~e_hc;
        e_cy = 0;
        e_ov = 0;
        e_par = ~^r[7:0];
        e_zr = bm ? (r[7:0] == 0) : (r == 0);
        e_sg = bm ? r[7] : r[15];
        tick("R2/R3/R4/R5/R6");
    endtask

    initial begin
        e_cy = 0; e_par = 0; e_hc = 0; e_zr = 0; e_sg = 0; e_ov = 0;
        e_ctl = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        cmp("R1", {flags_word, int_en, dir_down, single_step}, {16'h0002, 3'b000});
        // R11 fixed bits
        cmp("R11", {3'b000, flags_word & 16'hF02A}, {3'b000, 16'h0002});
        rst_n = 1'b1;

        // R9 set single-step and direction while arithmetic runs
        ctl_set = 3'b101;
        arith(0, 1, 8'h7F, 8'h01, 8'hC3);
        ctl_set = 3'b000;

        // byte-mode sweep (R7 boundaries included)
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b += 7) begin
                arith(0, 1, a, b, 8'(a * 3));
                arith(1, 1, a, b, 8'(b + 17));
            end
        end
        arith(1, 1, 8'h80, 8'h01, 8'hFF);
        arith(0, 1, 8'h80, 8'h80, 8'h00);
        arith(0, 1, 8'hFF, 8'h01, 8'h77);

        // word-mode edges and pseudo-random pairs
        arith(0, 0, 16'h7FFF, 16'h0001, 8'h00);
        arith(1, 0, 16'h8000, 16'h0001, 8'h00);
        arith(0, 0, 16'hFFFF, 16'h0001, 8'h00);
        arith(1, 0, 16'h0000, 16'h0000, 8'h00);
        arith(1, 0, 16'h0000, 16'h8000, 8'h00);
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r1;
            r1 = rnd();
            arith(i[0], 0, int'(r1[15:0]), int'(r1[31:16]), 8'h00);
        end

        // logical updates, R4 half-carry kept
        arith(0, 1, 8'h0F, 8'h01, 8'h11);
        logic_op(0, 16'h8001, 2'd2);
        logic_op(0, 16'h0000, 2'd3);
        logic_op(1, 16'hAB00, 2'd2);
        logic_op(1, 16'h00F0, 2'd3);
        for (int i = 0; i < 200; i++) begin
            logic [31:0] r2;
            r2 = rnd();
            logic_op(r2[20], r2[15:0], {1'b1, r2[21]});
        end

        // R8 hold with upd_en low and wild inputs
        arith(0, 1, 8'h80, 8'h80, 8'h00);
        for (int i = 0; i < 50; i++) begin
            logic [31:0] r3;
            r3 = rnd();
            upd_en = 1'b0;
            op_kind = r3[1:0];
            byte_mode = r3[2];
            result = r3[31:16];
            opnd_a = r3[15:0];
            opnd_b = ~r3[31:16];
            carry_out = r3[3];
            half_carry = r3[4];
            tick("R8");
        end

        // R9 control commands and priority; R10 gating
        upd_en = 1'b0;
        irq_req = 1'b1;
        @(negedge clk);
        cmp("R10", {18'd0, irq_take}, {18'd0, 1'b0});
        ctl_set = 3'b010; tick("R9");
        ctl_set = 3'b000;
        cmp("R10", {18'd0, irq_take}, {18'd0, 1'b1});
        irq_req = 1'b0; #1;
        cmp("R10", {18'd0, irq_take}, {18'd0, 1'b0});
        irq_req = 1'b1;
        ctl_set = 3'b111; ctl_clr = 3'b010; tick("R9");
        cmp("R10", {18'd0, irq_take}, {18'd0, 1'b0});
        ctl_set = 3'b000; ctl_clr = 3'b101; tick("R9");
        ctl_clr = 3'b000; ctl_set = 3'b110; tick("R9");
        ctl_set = 3'b000;
        arith(0, 0, 16'h1234, 16'h4321, 8'h00);
        logic_op(0, 16'h00FF, 2'd2);
        tick("R9");
        ctl_clr = 3'b111; tick("R9");
        ctl_clr = 3'b000;
        cmp("R10", {18'd0, irq_take}, {18'd0, 1'b0});

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule